// File: doc/BRIEF.md
# Counting Trigger Qualifier

This block sits between the condition comparators of an on-chip debug capture path and the capture buffer. Each clock it receives a single condition bit and turns it into a final one-cycle trigger strobe. The strobe timing depends on one of four counting modes and on a programmed count `N`. The modes are a fixed delay after the condition, the Nth rising edge of the condition, a minimum high duration, and an inactivity watchdog. One shared counter serves all four modes.

Software selects the mode and `N` while the unit is disarmed, then raises `arm`. While `arm` is low every count and pending state is held cleared, so each armed stretch starts from a clean state. A programmed `N` of zero behaves exactly like one. The `busy` output shows that a count is in progress: a delay is pending, or the shared counter holds a nonzero value.

Top module: `trig_qualifier`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released with `arm` low, `trig` and `busy` are 0.
- R2: Delay mode (`mode` = 2'b00). If the condition is sampled high at clock edge t while no delay is pending, `trig` is high for exactly the one cycle that follows edge t+N.
- R3: Delay mode. While a delay is pending, condition samples are ignored up to and including the edge at which the trigger fires. A condition held high therefore produces triggers spaced N+1 edges apart.
- R4: Count mode (`mode` = 2'b01). An occurrence is a rising edge of the condition: a high sample whose previous armed sample was low, with the sample just before arming treated as low. `trig` pulses in the cycle after every Nth occurrence, and the count then restarts. A level held for several cycles counts once.
- R5: Width mode (`mode` = 2'b10). `trig` pulses in the cycle after the Nth consecutive high sample. A low sample clears the run. Only one trigger is issued per continuous high stretch.
- R6: Watchdog mode (`mode` = 2'b11). `trig` pulses after N consecutive low samples. The inactivity count restarts on any high sample and on each trigger it issues, so a condition that stays low fires every N cycles.
- R7: An `n_val` of 0 behaves exactly like an `n_val` of 1 in every mode.
- R8: When `arm` is sampled low, all counting and pending state clears, and `trig` and `busy` are 0 in the following cycle.
- R9: `trig` is never high for two consecutive cycles except in watchdog mode with N equal to 1.
- R10: `busy` is high exactly when a count is in progress. In delay mode that means a delay is pending. In count mode, occurrences have been counted since the last trigger. In width mode, a high run is shorter than N. In watchdog mode, at least one low sample has been seen since the last restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Enables counting; low clears all state |
| cond | input | 1 | Trigger condition from the comparators |
| mode | input | 2 | Counting mode: 00 delay, 01 count, 10 width, 11 watchdog |
| n_val | input | NW | Programmed count N (0 acts as 1) |
| trig | output | 1 | One-cycle qualified trigger strobe |
| busy | output | 1 | A count or delay is in progress |

## Verification
Several properties are checked on every cycle: the pulse shape of `trig`, the clearing on disarm, the reset state, and the mode-specific condition that must have preceded a trigger. That condition is a high sample in count and width mode and a low sample in watchdog mode. The exact edge on which each trigger lands cannot be expressed by these properties, and neither can the `busy` level. The same holds for the rule that pending delays ignore new conditions, for held levels counting once, and for `n_val` of 0 matching 1. These need the bench's behavioural model, run through directed patterns and random condition streams in every mode.

// File: rtl/trq_pkg.sv
// Shared definitions for the counting trigger qualifier.
package trq_pkg;

    // Counting mode selected by software; the encoding is fixed at the ports.
    typedef enum logic [1:0] {
        TRQ_DELAY  = 2'b00,
        TRQ_COUNT  = 2'b01,
        TRQ_WIDTH  = 2'b10,
        TRQ_IDLEWD = 2'b11
    } trq_mode_e;

endpackage

// File: rtl/trq_cond_stage.sv
// Condition edge stage: keeps the previous armed sample of the condition
// and flags a rising edge. Assumes the condition is already synchronous to clk.
// The stored sample is cleared while disarmed, so a condition that is high
// at arming counts as an edge.
module trq_cond_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic cond,
    output logic cond_rise
);

    logic cond_q;

    // Store the last armed condition sample.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) begin
            cond_q <= 1'b0;
        end else begin
            cond_q <= cond;
        end
    end

    // A rising edge is a high sample after a low one.
    always_comb begin
        cond_rise = cond && !cond_q;
    end

endmodule

// File: rtl/trq_counter.sv
// Shared qualifier counter: counts up on inc and clears on clr (clr wins).
// It reports hit when one more step would reach the effective count, which
// is n_val with 0 promoted to 1. Assumes n_val is stable while armed.
module trq_counter #(
    parameter int NW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [NW-1:0] n_val,
    output logic          cnt_nz,
    output logic          hit
);

    localparam int CW = NW + 1;

    logic [NW-1:0] cnt_q;
    logic [NW-1:0] n_eff;
    logic [CW-1:0] next_step;

    // Effective terminal count, 0 promoted to 1.
    always_comb begin
        n_eff = (n_val == '0) ? NW'(1) : n_val;
    end

    // Compare the next count value against the terminal count.
    always_comb begin
        next_step = {1'b0, cnt_q} + CW'(1);
        hit       = (next_step == {1'b0, n_eff});
        cnt_nz    = (cnt_q != '0);
    end

    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= next_step[NW-1:0];
        end
    end

endmodule

// File: rtl/trq_mode_ctrl.sv
// Mode controller: turns the condition, its rising edge and the counter's
// hit flag into counter commands and a fire request, for the selected mode.
// The hold flag is the pending-delay flag in delay mode and the
// already-fired flag in width mode. Assumes mode is changed only while disarmed.
module trq_mode_ctrl
    import trq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic [1:0] mode,
    input  logic       cond,
    input  logic       cond_rise,
    input  logic       hit,
    output logic       inc,
    output logic       clr,
    output logic       fire,
    output logic       hold
);

    trq_mode_e mode_e;
    logic      hold_q;
    logic      hold_d;

    // Decode the mode bits.
    always_comb begin
        mode_e = trq_mode_e'(mode);
    end

    // Per-mode counter commands and fire decision.
    always_comb begin
        inc    = 1'b0;
        clr    = 1'b0;
        fire   = 1'b0;
        hold_d = hold_q;
        if (!arm) begin
            clr    = 1'b1;
            hold_d = 1'b0;
        end else begin
            case (mode_e)
                TRQ_DELAY: begin
                    if (hold_q) begin
                        if (hit) begin
                            fire   = 1'b1;
                            clr    = 1'b1;
                            hold_d = 1'b0;
                        end else begin
                            inc = 1'b1;
                        end
                    end else if (cond) begin
                        hold_d = 1'b1;
                    end
                end
                TRQ_COUNT: begin
                    if (cond_rise) begin
                        if (hit) begin
                            fire = 1'b1;
                            clr  = 1'b1;
                        end else begin
                            inc = 1'b1;
                        end
                    end
                end
                TRQ_WIDTH: begin
                    if (!cond) begin
                        clr    = 1'b1;
                        hold_d = 1'b0;
                    end else if (!hold_q) begin
                        if (hit) begin
                            fire   = 1'b1;
                            clr    = 1'b1;
                            hold_d = 1'b1;
                        end else begin
                            inc = 1'b1;
                        end
                    end
                end
                default: begin
                    if (cond) begin
                        clr = 1'b1;
                    end else if (hit) begin
                        fire = 1'b1;
                        clr  = 1'b1;
                    end else begin
                        inc = 1'b1;
                    end
                end
            endcase
        end
    end

    // Hold flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else begin
            hold_q <= hold_d;
        end
    end

    // Expose the hold flag for the status output.
    always_comb begin
        hold = hold_q;
    end

endmodule

// File: rtl/trig_qualifier.sv
// Counting trigger qualifier top: forms a one-cycle trigger strobe from a
// condition bit, using one of four counting modes and a programmed count.
// Assumes mode and n_val are programmed while arm is low.
module trig_qualifier
    import trq_pkg::*;
#(
    parameter int NW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          cond,
    input  logic [1:0]    mode,
    input  logic [NW-1:0] n_val,
    output logic          trig,
    output logic          busy
);

    logic cond_rise;
    logic cnt_nz;
    logic hit;
    logic inc;
    logic clr;
    logic fire;
    logic hold;
    logic trig_q;

    trq_cond_stage u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .cond      (cond),
        .cond_rise (cond_rise)
    );

    trq_counter #(.NW(NW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .inc    (inc),
        .n_val  (n_val),
        .cnt_nz (cnt_nz),
        .hit    (hit)
    );

    trq_mode_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .mode      (mode),
        .cond      (cond),
        .cond_rise (cond_rise),
        .hit       (hit),
        .inc       (inc),
        .clr       (clr),
        .fire      (fire),
        .hold      (hold)
    );

    // Register the fire request into the trigger strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
        end else begin
            trig_q <= fire;
        end
    end

    // Drive outputs: busy while counting or a delay is pending.
    always_comb begin
        trig = trig_q;
        busy = cnt_nz || (trq_mode_e'(mode) == TRQ_DELAY && hold);
    end

endmodule

// File: rtl/trig_qualifier_chk.sv
// Property checker for the counting trigger qualifier, bound to the top.
// Observes ports only.
module trig_qualifier_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       arm,
    input logic       cond,
    input logic [1:0] mode,
    input logic       trig,
    input logic       busy
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && !$past(arm)) |-> (!trig && !busy));

    // R8
    disarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (!trig && !busy));

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && mode != 2'b11) |=> (!trig || mode == 2'b11));

    // R4
    count_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && $past(arm) && $past(mode) == 2'b01) |-> $past(cond));

    // R5
    width_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && $past(arm) && $past(mode) == 2'b10) |-> $past(cond));

    // R6
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && $past(arm) && $past(mode) == 2'b11) |-> !$past(cond));

endmodule

bind trig_qualifier trig_qualifier_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (arm),
    .cond  (cond),
    .mode  (mode),
    .trig  (trig),
    .busy  (busy)
);

// File: tb/trig_qualifier_test.sv
// Bench for the counting trigger qualifier: a behavioural per-mode model
// updated on every clock edge and compared with the outputs each cycle.
module trig_qualifier_test;

    localparam int NW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm = 1'b0;
    logic          cond = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [NW-1:0] n_val = '0;
    logic          trig;
    logic          busy;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R1";
    bit    done = 1'b0;

    // Behavioural model state: separate counters per mode.
    bit m_trig = 1'b0;
    bit m_pend = 1'b0;
    int m_elapsed = 0;
    int m_events = 0;
    bit m_prev = 1'b0;
    int m_high = 0;
    int m_low = 0;

    trig_qualifier #(.NW(NW)) uut (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .cond  (cond),
        .mode  (mode),
        .n_val (n_val),
        .trig  (trig),
        .busy  (busy)
    );

    always #5 clk = ~clk;

    function automatic int eff_n();
        return (n_val == '0) ? 1 : int'(n_val);
    endfunction

    // Model update at each edge from the sampled inputs.
    always @(posedge clk) begin
        if (!rst_n || !arm) begin
            m_trig = 1'b0; m_pend = 1'b0; m_elapsed = 0; m_events = 0;
            m_prev = 1'b0; m_high = 0; m_low = 0;
        end else begin
            m_trig = 1'b0;
            case (mode)
                2'b00: begin
                    if (m_pend) begin
                        m_elapsed++;
                        if (m_elapsed == eff_n()) begin
                            m_trig = 1'b1;
                            m_pend = 1'b0;
                        end
                    end else if (cond) begin
                        m_pend = 1'b1;
                        m_elapsed = 0;
                    end
                end
                2'b01: begin
                    if (cond && !m_prev) begin
                        m_events++;
                        if (m_events == eff_n()) begin
                            m_trig = 1'b1;
                            m_events = 0;
                        end
                    end
                end
                2'b10: begin
                    if (cond) begin
                        m_high++;
                        if (m_high == eff_n()) m_trig = 1'b1;
                    end else begin
                        m_high = 0;
                    end
                end
                default: begin
                    if (cond) begin
                        m_low = 0;
                    end else begin
                        m_low++;
                        if (m_low == eff_n()) begin
                            m_trig = 1'b1;
                            m_low = 0;
                        end
                    end
                end
            endcase
            m_prev = cond;
        end
    end

    function automatic bit model_busy();
        case (mode)
            2'b00:   return m_pend;
            2'b01:   return m_events != 0;
            2'b10:   return m_high > 0 && m_high < eff_n();
            default: return m_low != 0;
        endcase
    endfunction

    // Compare outputs two time units after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!done) begin
                checks++;
                if (trig !== m_trig) begin
                    errors++;
                    $display("FAIL %s trig actual=%b expected=%b at %0t", cur_tag, trig, m_trig, $time);
                end
                checks++;
                if (busy !== model_busy()) begin
                    errors++;
                    $display("FAIL R10 busy (%s) actual=%b expected=%b at %0t", cur_tag, busy, model_busy(), $time);
                end
            end
        end
    end

    task automatic run(input bit c, input int k);
        for (int i = 0; i < k; i++) begin
            cond = c;
            @(negedge clk);
        end
    endtask

    task automatic setup(input logic [1:0] m, input int nv, input string tag);
        arm = 1'b0;
        cond = 1'b0;
        mode = m;
        n_val = NW'(nv);
        cur_tag = tag;
        @(negedge clk);
        arm = 1'b1;
    endtask

    task automatic random_run(input logic [1:0] m, input int nv, input string tag);
        setup(m, nv, tag);
        for (int i = 0; i < 60; i++) begin
            cond = ($urandom % 3) != 0;
            @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired in %s", cur_tag);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        run(1'b0, 3);
        rst_n = 1'b1;
        run(1'b0, 3);             // R1 reset state with arm low

        setup(2'b00, 3, "R2");    // R2 delay after condition
        run(1'b1, 1); run(1'b0, 6); run(1'b1, 1); run(1'b0, 5);

        setup(2'b00, 4, "R3");    // R3 conditions ignored while pending
        run(1'b1, 12); run(1'b0, 3); run(1'b1, 1); run(1'b0, 1); run(1'b1, 1); run(1'b0, 6);

        setup(2'b01, 3, "R4");    // R4 Nth rising edge, held levels count once
        run(1'b1, 3); run(1'b0, 2); run(1'b1, 1); run(1'b0, 1); run(1'b1, 4); run(1'b0, 3);
        run(1'b1, 1); run(1'b0, 1); run(1'b1, 1); run(1'b0, 1); run(1'b1, 1); run(1'b0, 2);

        setup(2'b10, 4, "R5");    // R5 sustained high width
        run(1'b1, 3); run(1'b0, 1); run(1'b1, 6); run(1'b0, 2); run(1'b1, 4); run(1'b0, 2);

        setup(2'b11, 5, "R6");    // R6 inactivity watchdog
        run(1'b0, 12); run(1'b1, 1); run(1'b0, 4); run(1'b1, 1); run(1'b0, 7);

        setup(2'b00, 0, "R7"); run(1'b1, 1); run(1'b0, 3);   // R7 zero acts as one
        setup(2'b01, 0, "R7"); run(1'b1, 2); run(1'b0, 1); run(1'b1, 1); run(1'b0, 2);
        setup(2'b10, 0, "R7"); run(1'b1, 3); run(1'b0, 1); run(1'b1, 1); run(1'b0, 2);
        setup(2'b11, 0, "R7"); run(1'b0, 4); run(1'b1, 1); run(1'b0, 2);

        setup(2'b01, 5, "R8");    // R8 disarm clears partial count
        run(1'b1, 1); run(1'b0, 1); run(1'b1, 1); run(1'b0, 1);
        arm = 1'b0; run(1'b1, 2); arm = 1'b1;
        run(1'b0, 1); run(1'b1, 1); run(1'b0, 1); run(1'b1, 1); run(1'b0, 1);
        run(1'b1, 1); run(1'b0, 1); run(1'b1, 1); run(1'b0, 1); run(1'b1, 1); run(1'b0, 2);
        setup(2'b00, 6, "R8");
        run(1'b1, 1); run(1'b0, 2);
        arm = 1'b0; run(1'b0, 1); arm = 1'b1; run(1'b0, 8);

        setup(2'b11, 1, "R9");    // R9 back-to-back only in watchdog with N=1
        run(1'b0, 4); run(1'b1, 2); run(1'b0, 3);
        setup(2'b10, 1, "R9"); run(1'b1, 5); run(1'b0, 1); run(1'b1, 1); run(1'b0, 2);

        for (int m = 0; m < 4; m++) begin
            for (int nv = 0; nv < 6; nv++) begin
                random_run(2'(m), nv, (m == 0) ? "R2" : (m == 1) ? "R4" : (m == 2) ? "R5" : "R6");
            end
        end

        arm = 1'b0;
        cur_tag = "R8";
        run(1'b0, 3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule